// File: doc/BRIEF.md
# Traceback Survivor Memory Manager

This block sits behind the add-compare-select array of a hard- or soft-decision Viterbi decoder. It keeps the survivor decisions and turns them into decoded bits by tracing back through the trellis. For each trellis stage the decoder presents one column of decision bits, with one bit per state. Alongside the column it presents the index of the state that currently holds the best path metric. The block stores the columns in four equal banks of `TB_DEPTH` columns each. Two walkers sweep these banks from newest to oldest column. The traceback walker follows the survivor chain without emitting anything, and it only finds a reliable starting state for the decode walker. The decode walker follows the chain through older data and emits one bit per column.

The decode walker yields bits newest-first. A pair of small stacks turns them back into time order. One stack is filled while the other is emptied, and the two swap roles at every bank boundary. All activity is paced by the column strobe. Each accepted column causes one write, one traceback step, one decode step and at most one output bit, so the block needs no clock-rate margin over the stage rate.

Top module: `tbk_survivor_mgr`

## Requirements
- R1: While reset is held, and in the first cycle after it, `out_valid` and `out_bit` are 0.
- R2: States are numbered with the most recent input bit as the MSB. The predecessor of state s under stored decision d is ((s << 1) | d) taken modulo NUM_STATES, and the bit decoded at a column is the MSB of the state occupied there.
- R3: Each traceback pass covers one bank, newest column first. It starts from the `in_best` value that arrived with the last column (position TB_DEPTH-1 of its bank) of the bank being traced. The `in_best` value on every other column has no effect on the output.
- R4: After L accepted columns since reset, exactly max(0, L − 4·TB_DEPTH − 1) output bits have been emitted. The first `out_valid` follows column number 4·TB_DEPTH+2.
- R5: For an error-free decision stream, the k-th emitted bit (k from 0) equals the input bit of trellis stage k. Bits therefore come out oldest first.
- R6: A column write never targets the bank that either walker is reading in that cycle.
- R7: `out_valid` is high for exactly one cycle, and only in the cycle after a column was accepted. Column data and `in_best` presented while `in_valid` is low are ignored, and idle gaps between columns do not alter the emitted sequence.
- R8: A synchronous reset in the middle of a stream discards all stored history. Output then resumes only after the full fill latency of R4 has elapsed again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | One trellis stage is presented this cycle |
| in_dec | input | NUM_STATES | Decision bit of every state for this stage |
| in_best | input | log2(NUM_STATES) | Index of the state with the best metric after this stage |
| out_valid | output | 1 | `out_bit` carries a decoded bit this cycle |
| out_bit | output | 1 | Decoded information bit, oldest first |

## Verification
The bench builds the block with its defaults: four states, with `TB_DEPTH` of 16, which gives a fill latency of 65 columns and a stack swap every 16 outputs. A rate-1/2, memory-2 encoder and a bench-side minimum-distance recursion produce the decision columns. This makes it possible to compare streams of several hundred bits against the encoder input. The streams include all-zero, all-one and alternating inputs, random idle gaps, and lengths of exactly 65 and 66 columns. Random `in_best` values on every non-final column and random data on idle cycles confirm that only the documented inputs steer the traceback.

// File: rtl/tbk_pkg.sv
package tbk_pkg;

  // Two read pointers (traceback + decode) need four banks of one
  // traceback depth each.
  localparam int unsigned BANK_BITS = 2;
  localparam int unsigned WARM_BITS = 3;

  typedef logic [BANK_BITS-1:0] bank_t;
  typedef logic [WARM_BITS-1:0] warm_t;

  // Number of completed banks after which each activity becomes legal.
  localparam warm_t WARM_TRACE  = 3'd1;
  localparam warm_t WARM_DECODE = 3'd3;
  localparam warm_t WARM_FULL   = 3'd4;

endpackage

// File: rtl/tbk_column_ram.sv
// Decision column store: one write port, two synchronous read ports.
module tbk_column_ram #(
  parameter int unsigned WIDTH = 4,
  parameter int unsigned DEPTH = 64,
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  input  logic [AW-1:0]    rd_a_addr,
  input  logic [AW-1:0]    rd_b_addr,
  output logic [WIDTH-1:0] rd_a_data,
  output logic [WIDTH-1:0] rd_b_data
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rd_en) begin
      rd_a_data <= mem[rd_a_addr];
      rd_b_data <= mem[rd_b_addr];
    end
  end

endmodule

// File: rtl/tbk_trace_walker.sv
// Follows one survivor chain, one column per step.
module tbk_trace_walker #(
  parameter int unsigned NUM_STATES = 4,
  parameter int unsigned SW         = $clog2(NUM_STATES)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  step,
  input  logic                  first,
  input  logic [SW-1:0]         start_state,
  input  logic [NUM_STATES-1:0] column,
  output logic [SW-1:0]         cur_state,
  output logic [SW-1:0]         nxt_state
);

  logic [SW-1:0] state_q;
  logic          pick;
  logic [SW:0]   widened;

  // A new pass begins at the supplied state; otherwise continue the chain.
  assign cur_state = first ? start_state : state_q;
  assign pick      = column[cur_state];
  // Predecessor: drop the newest bit, append the stored decision as the oldest.
  assign widened   = {cur_state, pick};
  assign nxt_state = widened[SW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= '0;
    end else if (step) begin
      state_q <= nxt_state;
    end
  end

endmodule

// File: rtl/tbk_order_stack.sv
// Ping-pong pair of LIFO stacks; one filled while the other is drained.
module tbk_order_stack #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned IW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          push_en,
  input  logic          push_sel,
  input  logic [IW-1:0] push_idx,
  input  logic          push_bit,
  input  logic          pop_sel,
  input  logic [IW-1:0] pop_idx,
  output logic          pop_bit
);

  logic [DEPTH-1:0] stk [2];

  for (genvar g = 0; g < 2; g++) begin : g_stack
    always_ff @(posedge clk) begin
      if (push_en && (push_sel == 1'(g))) begin
        stk[g][push_idx] <= push_bit;
      end
    end
  end

  assign pop_bit = stk[pop_sel][pop_idx];

endmodule

// File: rtl/tbk_survivor_mgr.sv
module tbk_survivor_mgr
  import tbk_pkg::*;
#(
  parameter int unsigned NUM_STATES = 4,
  parameter int unsigned TB_DEPTH   = 16
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            in_valid,
  input  logic [NUM_STATES-1:0]           in_dec,
  input  logic [$clog2(NUM_STATES)-1:0]   in_best,
  output logic                            out_valid,
  output logic                            out_bit
);

  localparam int unsigned SW    = $clog2(NUM_STATES);
  localparam int unsigned PW    = $clog2(TB_DEPTH);
  localparam int unsigned AW    = PW + BANK_BITS;
  localparam int unsigned COLS  = TB_DEPTH << BANK_BITS;
  localparam logic [PW-1:0] POS_LAST = PW'(TB_DEPTH - 1);

  // Write-side progress
  logic [PW-1:0] pos_q;
  bank_t         wbank_q;
  warm_t         warm_q;
  logic [SW-1:0] best_hold_q;
  logic [SW-1:0] dc_start_q;

  // Record of the reads issued on the previous accepted column
  logic          iss_live_q;
  logic [PW-1:0] iss_pos_q;
  bank_t         iss_bank_q;
  warm_t         iss_warm_q;

  logic [AW-1:0] wr_addr, tb_addr, dc_addr;
  logic [NUM_STATES-1:0] tb_col, dc_col;
  logic          step, tb_step, dc_step, pop_step;
  logic [SW-1:0] tb_cur, tb_nxt, dc_cur, dc_nxt;
  logic          pop_bit;
  logic          out_valid_q, out_bit_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q       <= '0;
      wbank_q     <= '0;
      warm_q      <= '0;
      best_hold_q <= '0;
      iss_live_q  <= 1'b0;
      iss_pos_q   <= '0;
      iss_bank_q  <= '0;
      iss_warm_q  <= '0;
    end else if (in_valid) begin
      pos_q      <= pos_q + 1'b1;
      iss_live_q <= 1'b1;
      iss_pos_q  <= pos_q;
      iss_bank_q <= wbank_q;
      iss_warm_q <= warm_q;
      if (pos_q == POS_LAST) begin
        wbank_q     <= wbank_q + 1'b1;
        best_hold_q <= in_best;
        if (warm_q != WARM_FULL) begin
          warm_q <= warm_q + 1'b1;
        end
      end
    end
  end

  // Writer fills bank w; traceback reads bank w-1; decode reads bank w-3.
  assign wr_addr = {wbank_q, pos_q};
  assign tb_addr = {bank_t'(wbank_q - 1'b1), POS_LAST - pos_q};
  assign dc_addr = {bank_t'(wbank_q + 1'b1), POS_LAST - pos_q};

  tbk_column_ram #(
    .WIDTH (NUM_STATES),
    .DEPTH (COLS),
    .AW    (AW)
  ) col_ram_i (
    .clk       (clk),
    .wr_en     (in_valid),
    .wr_addr   (wr_addr),
    .wr_data   (in_dec),
    .rd_en     (in_valid),
    .rd_a_addr (tb_addr),
    .rd_b_addr (dc_addr),
    .rd_a_data (tb_col),
    .rd_b_data (dc_col)
  );

  // R6
  wr_bank_free_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> (wr_addr[AW-1:PW] != tb_addr[AW-1:PW]) &&
                 (wr_addr[AW-1:PW] != dc_addr[AW-1:PW]));

  // Reads issued on one column are consumed on the next accepted column.
  assign step     = in_valid && iss_live_q;
  assign tb_step  = step && (iss_warm_q >= WARM_TRACE);
  assign dc_step  = step && (iss_warm_q >= WARM_DECODE);
  assign pop_step = step && (iss_warm_q == WARM_FULL);

  tbk_trace_walker #(
    .NUM_STATES (NUM_STATES),
    .SW         (SW)
  ) tb_walk_i (
    .clk         (clk),
    .rst         (rst),
    .step        (tb_step),
    .first       (iss_pos_q == '0),
    .start_state (best_hold_q),
    .column      (tb_col),
    .cur_state   (tb_cur),
    .nxt_state   (tb_nxt)
  );

  // The state reached at the oldest column of a traced bank seeds decoding.
  always_ff @(posedge clk) begin
    if (rst) begin
      dc_start_q <= '0;
    end else if (tb_step && (iss_pos_q == POS_LAST)) begin
      dc_start_q <= tb_nxt;
    end
  end

  tbk_trace_walker #(
    .NUM_STATES (NUM_STATES),
    .SW         (SW)
  ) dc_walk_i (
    .clk         (clk),
    .rst         (rst),
    .step        (dc_step),
    .first       (iss_pos_q == '0),
    .start_state (dc_start_q),
    .column      (dc_col),
    .cur_state   (dc_cur),
    .nxt_state   (dc_nxt)
  );

  tbk_order_stack #(
    .DEPTH (TB_DEPTH),
    .IW    (PW)
  ) order_i (
    .clk      (clk),
    .push_en  (dc_step),
    .push_sel (iss_bank_q[0]),
    .push_idx (iss_pos_q),
    .push_bit (dc_cur[SW-1]),
    .pop_sel  (~iss_bank_q[0]),
    .pop_idx  (POS_LAST - iss_pos_q),
    .pop_bit  (pop_bit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid_q <= 1'b0;
      out_bit_q   <= 1'b0;
    end else begin
      out_valid_q <= pop_step;
      if (pop_step) begin
        out_bit_q <= pop_bit;
      end
    end
  end

  assign out_valid = out_valid_q;
  assign out_bit   = out_bit_q;

  // R4
  out_after_fill_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (warm_q == WARM_FULL));

  // R4
  fill_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (warm_q == WARM_FULL) |=> (warm_q == WARM_FULL));

  // R7
  out_needs_col_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid));

  // R7
  no_idle_out_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !in_valid) |=> !out_valid);

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(pos_q) && $stable(wbank_q));

  logic unused_ok;
  assign unused_ok = ^{tb_cur, dc_nxt};

endmodule

// File: tb/tbk_survivor_mgr_tb_top.sv
module tbk_survivor_mgr_tb_top;

  localparam int NS   = 4;
  localparam int TD   = 16;
  localparam int LAT  = 4 * TD + 1;
  localparam int MAXL = 1024;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [NS-1:0] in_dec = '0;
  logic [1:0]    in_best = '0;
  logic          out_valid;
  logic          out_bit;

  always #2 clk = ~clk;

  tbk_survivor_mgr #(.NUM_STATES(NS), .TB_DEPTH(TD)) dut_i (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_dec    (in_dec),
    .in_best   (in_best),
    .out_valid (out_valid),
    .out_bit   (out_bit)
  );

  int errors = 0;
  int checks = 0;
  bit u_bits [MAXL];
  bit got    [MAXL];
  int got_n  = 0;
  int stray_n = 0;
  logic last_iv = 1'b0;
  int pm [NS];
  bit e1, e2;

  always @(posedge clk) last_iv <= in_valid;

  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (!last_iv) stray_n++;
      if (got_n < MAXL) got[got_n] = out_bit;
      got_n++;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic ref_reset();
    for (int s = 0; s < NS; s++) pm[s] = (s == 0) ? 0 : 1000;
    e1 = 1'b0;
    e2 = 1'b0;
  endtask

  // Bench-side minimum-distance recursion for a noiseless channel (R2 numbering).
  task automatic ref_column(input bit u, output logic [NS-1:0] dec, output logic [1:0] best);
    int np [NS];
    bit c1, c2;
    c1 = u ^ e1 ^ e2;
    c2 = u ^ e2;
    for (int s = 0; s < NS; s++) begin
      int m [2];
      for (int d = 0; d < 2; d++) begin
        int p;
        bit x1, x2, uin;
        p   = ((s << 1) | d) & (NS - 1);
        uin = bit'((s >> 1) & 1);
        x1  = uin ^ bit'((p >> 1) & 1) ^ bit'(p & 1);
        x2  = uin ^ bit'(p & 1);
        m[d] = pm[p] + int'(x1 != c1) + int'(x2 != c2);
      end
      dec[s] = (m[1] < m[0]);
      np[s]  = (m[1] < m[0]) ? m[1] : m[0];
    end
    best = 2'd0;
    for (int s = 1; s < NS; s++) if (np[s] < np[best]) best = 2'(s);
    for (int s = 0; s < NS; s++) pm[s] = np[s];
    e2 = e1;
    e1 = u;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    got_n = 0;
    stray_n = 0;
  endtask

  function automatic bit pattern(input int mode, input int c);
    case (mode)
      1: return 1'b0;
      2: return 1'b1;
      3: return bit'(c & 1);
      default: return bit'($urandom & 1);
    endcase
  endfunction

  // Feeds a stream; in_best is only meaningful on the last column of a bank (R3).
  task automatic feed(input int mode, input int len, input int max_stall);
    ref_reset();
    for (int c = 0; c < len; c++) begin
      bit u;
      logic [NS-1:0] dec;
      logic [1:0] best;
      u = pattern(mode, c);
      u_bits[c] = u;
      ref_column(u, dec, best);
      @(negedge clk);
      in_valid = 1'b1;
      in_dec   = dec;
      in_best  = ((c % TD) == TD - 1) ? best : 2'($urandom);
      if (max_stall > 0) begin
        int k;
        k = $urandom_range(max_stall, 0);
        repeat (k) begin
          @(negedge clk);
          in_valid = 1'b0;
          in_dec   = NS'($urandom);
          in_best  = 2'($urandom);
        end
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic judge(input string name, input int len);
    int exp_n, mism, first_bad;
    exp_n = (len > LAT) ? len - LAT : 0;
    check(got_n == exp_n, "R4", {name, " output count"}, got_n, exp_n);
    mism = 0;
    first_bad = -1;
    for (int k = 0; k < got_n && k < exp_n; k++) begin
      if (got[k] != u_bits[k]) begin
        if (first_bad < 0) first_bad = k;
        mism++;
      end
    end
    // R2 R3 R5: decoded bits equal encoder input in order
    check(mism == 0, "R5", {name, " mismatched bits (first index in log)"}, mism, 0);
    if (mism != 0) $display("  first mismatch at bit %0d", first_bad);
    check(stray_n == 0, "R7", {name, " outputs without a column"}, stray_n, 0);
  endtask

  task automatic t_reset_state();
    // R1
    @(negedge clk);
    check(out_valid == 1'b0 && out_bit == 1'b0, "R1", "outputs during reset",
          int'({out_valid, out_bit}), 0);
    rst = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0 && out_bit == 1'b0, "R1", "outputs after reset",
          int'({out_valid, out_bit}), 0);
  endtask

  task automatic t_random();
    do_reset(); feed(0, 300, 0); judge("random", 300);
  endtask

  task automatic t_zeros();
    do_reset(); feed(1, 120, 0); judge("zeros", 120);
  endtask

  task automatic t_ones();
    do_reset(); feed(2, 120, 0); judge("ones", 120);
  endtask

  task automatic t_alt_stall();
    // R7 idle gaps with junk inputs
    do_reset(); feed(3, 150, 2); judge("alternating+gaps", 150);
  endtask

  task automatic t_random_stall();
    do_reset(); feed(0, 200, 3); judge("random+gaps", 200);
  endtask

  task automatic t_boundary();
    // R4 exact fill boundary
    do_reset(); feed(0, LAT, 0); judge("len=fill", LAT);
    do_reset(); feed(0, LAT + 1, 0); judge("len=fill+1", LAT + 1);
  endtask

  task automatic t_midstream_reset();
    // R8
    do_reset(); feed(0, 100, 0);
    check(got_n == 100 - LAT, "R8", "outputs before reset", got_n, 100 - LAT);
    do_reset();
    check(out_valid == 1'b0, "R8", "out_valid after mid-stream reset", int'(out_valid), 0);
    feed(0, 70, 0); judge("after reset", 70);
  endtask

  initial begin
    t_reset_state();
    t_random();
    t_zeros();
    t_ones();
    t_alt_stall();
    t_random_stall();
    t_boundary();
    t_midstream_reset();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule